// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog made of two cascaded down counters that advance only on a slow periodic tick-enable input. The primary counter is 16 bits wide and runs first. When it expires, the block raises a timeout indicator pin and can set an interrupt flag. The 8-bit grace counter then starts. If software or hardware has not retriggered the watchdog by the time the grace counter also expires, the selected final action happens: either a one-clock reset request or a second raise of the interrupt flag.

Software drives the block through an 8-bit control write, a command port and a reload-value write port for each counter. A retrigger comes from one of three sources: a software command, an edge on a dedicated input pin (synchronized, with selectable polarity), or turning the watchdog on. An early option raises the indicator one tick before the primary counter expires. Looping the indicator back onto the retrigger pin, set for rising edges, then makes the watchdog retrigger itself over and over. The block does not drive pin direction itself. It reports on an output whether it currently owns the two pins.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset, ind_pin, irq, rst_req and pins_owned are all 0, and the reload values are all ones.
- R2: A control write with bit0 (enable) = 1, bits 1 and 2 both 0, while the watchdog is off turns it on. This write loads both counters, drives ind_pin low and sets pins_owned. With the early option off, ind_pin goes high on exactly the Nth tick afterwards, where N (N >= 2) is the primary reload value.
- R3: Once the primary counter has expired, the grace counter counts ticks. When bit6 (final select) = 0, rst_req is high for exactly one clock on the Mth tick after primary expiry, where M is the grace reload value. Both counters then hold, and no further rst_req pulse occurs until a retrigger.
- R4: When bit5 (interrupt enable) = 1, irq is set at primary expiry. When it is 0, irq stays low at primary expiry.
- R5: When bit6 (final select) = 1, grace expiry sets irq and produces no rst_req pulse.
- R6: A control write with bit1 = 1 is a software retrigger. While the watchdog is on, it reloads both counters and drives ind_pin low. It leaves every configuration bit unchanged. A software retrigger and a hardware retrigger in the same cycle act as one retrigger.
- R7: A control write with bit2 = 1 and bit1 = 0 clears irq. It does not retrigger (ind_pin keeps its value) and leaves every configuration bit unchanged.
- R8: When bit3 (hardware retrigger enable) = 1, the input trig_pin passes through a two-flop synchronizer. An edge on it then retriggers the watchdog: a rising edge when bit4 = 0, a falling edge when bit4 = 1. The opposite edge, or any edge while bit3 = 0, has no effect.
- R9: When bit7 (early) = 1, ind_pin goes high on the tick that takes the primary counter to 1. With ind_pin looped onto trig_pin, bit3 = 1 and bit4 = 0, the watchdog retriggers itself and never reaches the final action.
- R10: A control write with bits 0, 1 and 2 all 0 turns the watchdog off. It clears irq, drives ind_pin low and clears pins_owned. Ticks that follow have no effect.
- R11: Counters change only in a cycle with tick_en high. Without ticks, ind_pin keeps its value indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-clock periodic count enable |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control data: bit0 enable, bit1 retrigger cmd, bit2 irq-clear cmd, bit3 hw retrigger enable, bit4 falling edge, bit5 irq enable, bit6 final select, bit7 early |
| rl_a_we | input | 1 | Primary reload write strobe |
| rl_a | input | 16 | Primary reload value |
| rl_b_we | input | 1 | Grace reload write strobe |
| rl_b | input | 8 | Grace reload value |
| trig_pin | input | 1 | Hardware retrigger input pin |
| ind_pin | output | 1 | Timeout indicator pin |
| pins_owned | output | 1 | Watchdog owns trig_pin and ind_pin |
| irq | output | 1 | Interrupt flag / request |
| rst_req | output | 1 | One-clock final reset request |

## Verification
A wrong counter value or a wrong phase has only one visible effect at the ports: ind_pin or rst_req moves on the wrong tick. The bench therefore counts ticks from each reload and samples ind_pin after every tick. With that sampling, an off-by-one in either counter shows up on the first expiry that follows. A stuck phase shows up as a missing or repeated rst_req pulse within the next grace interval. A broken synchronizer or edge select leaves ind_pin high three clocks after a pin edge, when a retrigger should already have lowered it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CB_EN    = 0;
  localparam int CB_TRIG  = 1;
  localparam int CB_ICLR  = 2;
  localparam int CB_HWEN  = 3;
  localparam int CB_FALL  = 4;
  localparam int CB_INTEN = 5;
  localparam int CB_FSEL  = 6;
  localparam int CB_EARLY = 7;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MAIN = 2'd1,
    PH_GRACE = 2'd2,
    PH_HOLD = 2'd3
  } wdt_phase_e;

  typedef struct packed {
    logic early;
    logic fsel;
    logic inten;
    logic fall;
    logic hwen;
    logic en;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_edge_det.sv
module wdt_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic prev_q;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_comb begin
    if (fall_sel) edge_o = prev_q & ~sync_q[SYNC_STAGES-1];
    else          edge_o = sync_q[SYNC_STAGES-1] & ~prev_q;
  end
endmodule

// File: rtl/wdt_dctr.sv
module wdt_dctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (load)                  cnt_d = load_val;
    else if (dec && cnt != '0) cnt_d = cnt - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int A_W = 16,
  parameter int B_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic           ctl_we,
  input  logic [7:0]     ctl_wdata,
  input  logic           rl_a_we,
  input  logic [A_W-1:0] rl_a,
  input  logic           rl_b_we,
  input  logic [B_W-1:0] rl_b,
  input  logic           trig_pin,
  output logic           ind_pin,
  output logic           pins_owned,
  output logic           irq,
  output logic           rst_req
);
  localparam logic [A_W-1:0] A_ONE = A_W'(1);
  localparam logic [A_W-1:0] A_TWO = A_W'(2);
  localparam logic [B_W-1:0] B_ONE = B_W'(1);

  wdt_cfg_t      cfg_q, cfg_d;
  wdt_phase_e    ph_q, ph_d;
  logic [A_W-1:0] rla_q, rla_d, cnt_a;
  logic [B_W-1:0] rlb_q, rlb_d, cnt_b;
  logic ind_d, irq_d, rreq_d;

  logic wr_trig, wr_iclr, wr_cfg, en_rise, en_fall;
  logic hw_edge, retrig, ticking, in_main, in_grace;
  logic a_exp, b_exp, a_early;

  wdt_edge_det #(.SYNC_STAGES(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(trig_pin),
    .fall_sel(cfg_q.fall), .edge_o(hw_edge)
  );

  wdt_dctr #(.W(A_W)) u_cnt_a (
    .clk(clk), .rst_n(rst_n), .load(retrig), .load_val(rla_q),
    .dec(ticking & in_main), .cnt(cnt_a)
  );

  wdt_dctr #(.W(B_W)) u_cnt_b (
    .clk(clk), .rst_n(rst_n), .load(retrig), .load_val(rlb_q),
    .dec(ticking & in_grace), .cnt(cnt_b)
  );

  // command decode: either command bit suppresses the configuration update
  always_comb begin
    wr_trig = ctl_we & ctl_wdata[CB_TRIG];
    wr_iclr = ctl_we & ctl_wdata[CB_ICLR] & ~ctl_wdata[CB_TRIG];
    wr_cfg  = ctl_we & ~ctl_wdata[CB_TRIG] & ~ctl_wdata[CB_ICLR];
    en_rise = wr_cfg & ctl_wdata[CB_EN] & ~cfg_q.en;
    en_fall = wr_cfg & ~ctl_wdata[CB_EN] & cfg_q.en;
    // sw and hw sources merge into a single reload
    retrig  = en_rise | (cfg_q.en & (wr_trig | (cfg_q.hwen & hw_edge)));
    ticking = cfg_q.en & tick_en & ~retrig & ~en_fall;
    in_main  = (ph_q == PH_MAIN);
    in_grace = (ph_q == PH_GRACE);
    a_exp   = ticking & in_main & (cnt_a <= A_ONE);
    a_early = ticking & in_main & cfg_q.early & (cnt_a == A_TWO);
    b_exp   = ticking & in_grace & (cnt_b <= B_ONE);
  end

  always_comb begin
    cfg_d = cfg_q;
    if (wr_cfg) begin
      cfg_d.en    = ctl_wdata[CB_EN];
      cfg_d.hwen  = ctl_wdata[CB_HWEN];
      cfg_d.fall  = ctl_wdata[CB_FALL];
      cfg_d.inten = ctl_wdata[CB_INTEN];
      cfg_d.fsel  = ctl_wdata[CB_FSEL];
      cfg_d.early = ctl_wdata[CB_EARLY];
    end
    rla_d = rl_a_we ? rl_a : rla_q;
    rlb_d = rl_b_we ? rl_b : rlb_q;
  end

  always_comb begin
    ph_d   = ph_q;
    ind_d  = ind_pin;
    irq_d  = irq;
    rreq_d = 1'b0;
    if (en_fall) begin
      ph_d  = PH_IDLE;
      ind_d = 1'b0;
    end else if (retrig) begin
      ph_d  = PH_MAIN;
      ind_d = 1'b0;
    end else if (a_exp) begin
      ph_d  = PH_GRACE;
      ind_d = 1'b1;
    end else if (b_exp) begin
      ph_d   = PH_HOLD;
      rreq_d = ~cfg_q.fsel;
    end else if (a_early) begin
      ind_d = 1'b1;
    end
    if (wr_iclr) irq_d = 1'b0;
    if ((a_exp & cfg_q.inten) | (b_exp & cfg_q.fsel)) irq_d = 1'b1;
    if (en_fall) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      ph_q    <= PH_IDLE;
      rla_q   <= '1;
      rlb_q   <= '1;
      ind_pin <= 1'b0;
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      ph_q    <= ph_d;
      rla_q   <= rla_d;
      rlb_q   <= rlb_d;
      ind_pin <= ind_d;
      irq     <= irq_d;
      rst_req <= rreq_d;
    end
  end

  assign pins_owned = cfg_q.en;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_en,
  input logic cmd_trig,
  input logic cmd_iclr,
  input logic ind_pin,
  input logic pins_owned,
  input logic irq,
  input logic rst_req
);
  // R3: final reset request lasts one clock
  a_r3_rst_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R3: a reset request only comes while the indicator is high
  a_r3_rst_with_ind: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ind_pin);

  // R10: an idle watchdog drives nothing
  a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_owned |-> (!ind_pin && !irq && !rst_req));

  // R6: a software retrigger lowers the indicator
  a_r6_trig_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_owned && cmd_trig) |=> !ind_pin);

  // R7: clear command without a tick leaves irq low
  a_r7_iclr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_iclr && !tick_en) |=> !irq);

  // R11: indicator only rises on a tick
  a_r11_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ind_pin) |-> $past(tick_en));
endmodule

bind wdt_two_stage wdt_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .tick_en(tick_en),
  .cmd_trig(ctl_we & ctl_wdata[1]),
  .cmd_iclr(ctl_we & ctl_wdata[2] & ~ctl_wdata[1]),
  .ind_pin(ind_pin),
  .pins_owned(pins_owned),
  .irq(irq),
  .rst_req(rst_req)
);

// File: tb/sim_wdt_two_stage.sv
`timescale 1ns/1ps
module sim_wdt_two_stage;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic rl_a_we = 1'b0;
  logic [15:0] rl_a = 16'h0;
  logic rl_b_we = 1'b0;
  logic [7:0] rl_b = 8'h0;
  logic pin_val = 1'b0;
  logic loop_on = 1'b0;
  logic trig_pin;
  logic ind_pin, pins_owned, irq, rst_req;

  int n_chk = 0;
  int n_bad = 0;
  int rst_cnt = 0;
  int cyc = 0;
  bit done = 1'b0;

  assign trig_pin = loop_on ? ind_pin : pin_val;

  always #10 clk = ~clk;

  wdt_two_stage u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .rl_a_we(rl_a_we), .rl_a(rl_a), .rl_b_we(rl_b_we), .rl_b(rl_b),
    .trig_pin(trig_pin), .ind_pin(ind_pin), .pins_owned(pins_owned),
    .irq(irq), .rst_req(rst_req)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_req) rst_cnt <= rst_cnt + 1;
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog expired: act=%0d exp=<20000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_en = 1'b1;
      @(negedge clk) tick_en = 1'b0;
      idle(4);
    end
  endtask

  task automatic ctl(input logic [7:0] d);
    @(negedge clk) begin ctl_we = 1'b1; ctl_wdata = d; end
    @(negedge clk) begin ctl_we = 1'b0; ctl_wdata = 8'h00; end
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk) pin_val = v;
    idle(6);
  endtask

  task automatic t_reset();
    chk("R1 ind", int'(ind_pin), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 rst_req", int'(rst_req), 0);
    chk("R1 pins_owned", int'(pins_owned), 0);
  endtask

  task automatic t_primary_grace();
    int r0;
    ctl(8'h01);
    chk("R2 owned after enable", int'(pins_owned), 1);
    chk("R2 ind low after enable", int'(ind_pin), 0);
    tick(3);
    chk("R2 ind low before N ticks", int'(ind_pin), 0);
    tick(1);
    chk("R2 ind high on Nth tick", int'(ind_pin), 1);
    chk("R4 no irq when disabled", int'(irq), 0);
    r0 = rst_cnt;
    tick(2);
    chk("R3 no rst before M ticks", rst_cnt - r0, 0);
    tick(1);
    chk("R3 one rst pulse on Mth tick", rst_cnt - r0, 1);
    tick(5);
    chk("R3 counters hold, no repeat", rst_cnt - r0, 1);
  endtask

  task automatic t_sw_retrig();
    ctl(8'h02);
    chk("R6 retrigger lowers ind", int'(ind_pin), 0);
    chk("R6 enable bit kept", int'(pins_owned), 1);
    idle(60);
    chk("R11 no change without ticks", int'(ind_pin), 0);
    tick(3);
    chk("R6 reloaded primary, 3 ticks", int'(ind_pin), 0);
    tick(1);
    chk("R6 reloaded primary, 4 ticks", int'(ind_pin), 1);
  endtask

  task automatic t_irq_paths();
    int r0;
    ctl(8'h00);
    ctl(8'h61);
    tick(4);
    chk("R4 irq at primary expiry", int'(irq), 1);
    ctl(8'h04);
    chk("R7 irq cleared", int'(irq), 0);
    chk("R7 no retrigger", int'(ind_pin), 1);
    chk("R7 enable kept", int'(pins_owned), 1);
    r0 = rst_cnt;
    tick(3);
    chk("R5 irq at grace expiry", int'(irq), 1);
    chk("R5 no rst pulse", rst_cnt - r0, 0);
    ctl(8'h00);
    chk("R10 irq cleared", int'(irq), 0);
    chk("R10 ind low", int'(ind_pin), 0);
    chk("R10 pins released", int'(pins_owned), 0);
    tick(10);
    chk("R10 ticks ignored ind", int'(ind_pin), 0);
    chk("R10 ticks ignored rst", rst_cnt - r0, 0);
  endtask

  task automatic t_hw_retrig();
    ctl(8'h09);
    tick(3);
    set_pin(1'b1);
    tick(3);
    chk("R8 rising edge reloaded", int'(ind_pin), 0);
    tick(1);
    chk("R8 expiry after reload", int'(ind_pin), 1);
    set_pin(1'b0);
    chk("R8 falling ignored in rising mode", int'(ind_pin), 1);
    ctl(8'h00);
    set_pin(1'b1);
    ctl(8'h19);
    tick(4);
    chk("R8 expiry in falling mode", int'(ind_pin), 1);
    set_pin(1'b0);
    chk("R8 falling edge retriggers", int'(ind_pin), 0);
    ctl(8'h00);
    ctl(8'h01);
    tick(4);
    set_pin(1'b1);
    set_pin(1'b0);
    chk("R8 edges ignored when hw off", int'(ind_pin), 1);
  endtask

  task automatic t_early();
    int r0;
    ctl(8'h00);
    ctl(8'h81);
    tick(2);
    chk("R9 ind low at count 2", int'(ind_pin), 0);
    tick(1);
    chk("R9 early ind at count 1", int'(ind_pin), 1);
    ctl(8'h00);
    loop_on = 1'b1;
    ctl(8'h89);
    r0 = rst_cnt;
    tick(40);
    chk("R9 loopback prevents final action", rst_cnt - r0, 0);
    chk("R9 loopback still owned", int'(pins_owned), 1);
    loop_on = 1'b0;
    ctl(8'h00);
  endtask

  initial begin
    idle(3);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    t_reset();
    @(negedge clk) begin rl_a_we = 1'b1; rl_a = 16'd4; rl_b_we = 1'b1; rl_b = 8'd3; end
    @(negedge clk) begin rl_a_we = 1'b0; rl_b_we = 1'b0; end
    t_primary_grace();
    t_sw_retrig();
    t_irq_paths();
    t_hw_retrig();
    t_early();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule